// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message-signalled interrupt table of one function: for each vector it stores a 64-bit message address, 32 bits of message data and a mask flag. Software reaches the table, and a read-only array of pending flags, through a 4 KB register window. The window accepts only full 32-bit accesses. The block also holds the capability control word, in which the global enable bit is the only writable field. Two read-only location words report where the table and the pending array sit and which base address register holds them.

Interrupt sources inside the function raise a request for a vector number. When the function is enabled and the vector is usable, the block presents a write message carrying that vector's address and data on a valid/ready output. A vector is usable when its mask is clear and its data is nonzero. A request on a masked vector, or one that arrives while the output is occupied, is recorded as pending. It is sent once the vector can be delivered and the output is free. Requests that can never be delivered are discarded.

Top module: `msix_vector_table`

## Requirements
- R1: After reset every entry reads mask 1, address 0 and data 0, the pending array reads 0, the enable bit is 0 and no message is valid.
- R2: Entry n occupies window bytes 16n..16n+15, with address low at +0, address high at +4, data at +8 and vector control at +12. Only bit 0 of vector control (the mask) is stored; its other bits read 0.
- R3: The control word returns NUM_VEC-1 in bits 10:0 and the enable in bit 15, with all other bits 0. A control write changes bit 15 only.
- R4: Only accesses with size code 2 (4 bytes) on a 4-byte-aligned address take effect. Other reads return 0 and other writes are dropped. Accesses to entries at or above NUM_VEC read 0 and drop writes.
- R5: The pending array starts at byte 0x800, one bit per vector with vector 0 in bit 0 of the first word, and ignores writes. The table location word reads BIR and the pending location word reads 0x800 | BIR, with the register indicator in bits 2:0.
- R6: When the enable goes from 0 to 1, each entry becomes usable exactly when its mask is clear and its data is nonzero. While the function is enabled, a table write re-decides this for that entry. While the function is disabled, no entry is usable.
- R7: A request while disabled, on a vector number of NUM_VEC or above, or on an unmasked vector with zero data produces no message and sets no pending bit.
- R8: A request on a usable vector while the output is free presents, in the next cycle, msg_addr = {address high, address low} and msg_data = data of that entry.
- R9: A request on a masked vector with nonzero data sets that vector's pending bit and produces no message.
- R10: A pending vector that becomes usable while enabled is sent when the output is free, and its pending bit clears. The lowest-numbered such vector goes first, and a direct request takes the output before any pending vector.
- R11: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold.
- R12: A request on a usable vector while the output is occupied sets the vector's pending bit, and the message is sent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_req | input | 1 | Window access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address within the window |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| cap_we | input | 1 | Control word write strobe |
| cap_wdata | input | 16 | Control word write data |
| cap_ctrl | output | 16 | Control word |
| tbl_loc | output | 32 | Table location word |
| pba_loc | output | 32 | Pending array location word |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 11 | Requested vector number |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with five vectors and register indicator 2. With five vectors, a request on vector 7 and an access to entry 5 fall outside the table. Five vectors also leave the upper bits of the pending word unused, where a stray bit would show. Five is not a power of two, so index truncation errors become visible. Holding msg_ready low lets pending requests collect behind an occupied output, which exercises the lowest-first drain order and the hold of the output.

// File: rtl/msix_vector_table.sv
module msix_vector_table #(
  parameter int NUM_VEC = 8,
  parameter int BIR     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [1:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cap_we,
  input  logic [15:0] cap_wdata,
  output logic [15:0] cap_ctrl,
  output logic [31:0] tbl_loc,
  output logic [31:0] pba_loc,
  input  logic        irq_req,
  input  logic [10:0] irq_vec,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int PBA_W = (NUM_VEC + 31) / 32;
  localparam int PW_W  = (PBA_W > 1) ? $clog2(PBA_W) : 1;
  localparam logic [7:0]  NV8  = 8'(NUM_VEC);
  localparam logic [10:0] NV11 = 11'(NUM_VEC);
  localparam logic [8:0]  PW9  = 9'(PBA_W);

  logic [31:0] alo_q [NUM_VEC];
  logic [31:0] ahi_q [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q, used_q, pend_q;
  logic en_q;

  logic unused_cap;
  assign unused_cap = ^cap_wdata[14:0];

  assign cap_ctrl = {en_q, 4'b0, 11'(NUM_VEC - 1)};
  assign tbl_loc  = {29'd0, 3'(BIR)};
  assign pba_loc  = {20'd0, 1'b1, 8'd0, 3'(BIR)};

  logic full, tbl_hit, pba_hit;
  logic [6:0] ent;
  logic [1:0] word;
  logic [8:0] pw;
  logic [IDX_W-1:0] ent_i;

  assign full    = (reg_size == 2'd2) && (reg_addr[1:0] == 2'd0);
  assign ent     = reg_addr[10:4];
  assign word    = reg_addr[3:2];
  assign pw      = reg_addr[10:2];
  assign ent_i   = ent[IDX_W-1:0];
  assign tbl_hit = full && !reg_addr[11] && ({1'b0, ent} < NV8);
  assign pba_hit = full &&  reg_addr[11] && (pw < PW9);

  logic [PBA_W*32-1:0] pend_ext;
  logic [31:0] pba_word [PBA_W];
  assign pend_ext = (PBA_W*32)'(pend_q);
  for (genvar w = 0; w < PBA_W; w++) begin : g_pba
    assign pba_word[w] = pend_ext[w*32 +: 32];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_req && !reg_we) begin
      if (tbl_hit) begin
        case (word)
          2'd0:    reg_rdata = alo_q[ent_i];
          2'd1:    reg_rdata = ahi_q[ent_i];
          2'd2:    reg_rdata = dat_q[ent_i];
          default: reg_rdata = {31'd0, mask_q[ent_i]};
        endcase
      end else if (pba_hit) begin
        reg_rdata = pba_word[pw[PW_W-1:0]];
      end
    end
  end

  logic en_next, en_rise, wr;
  assign en_next = cap_we ? cap_wdata[15] : en_q;
  assign en_rise = en_next && !en_q;
  assign wr      = reg_req && reg_we && tbl_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_next;

  logic free, v_ok, send_now, to_pend, rel_go;
  logic [IDX_W-1:0] vi, rel_idx, src;
  logic [NUM_VEC-1:0] rel_cand, rel_oh, set_pend;

  assign free     = !msg_valid || msg_ready;
  assign vi       = irq_vec[IDX_W-1:0];
  assign v_ok     = irq_req && en_q && (irq_vec < NV11);
  assign send_now = v_ok && used_q[vi] && free;
  assign to_pend  = v_ok && (mask_q[vi] ? (dat_q[vi] != 32'd0) : (used_q[vi] && !free));
  assign rel_cand = pend_q & used_q & {NUM_VEC{en_q}};
  assign rel_oh   = rel_cand & (~rel_cand + 1'b1);
  assign rel_go   = free && !send_now && (|rel_cand);
  assign set_pend = to_pend ? (NUM_VEC'(1) << vi) : '0;
  assign src      = send_now ? vi : rel_idx;

  always_comb begin
    rel_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (rel_cand[i]) rel_idx = IDX_W'(i);
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic hit;
    logic mask_n;
    logic [31:0] dat_n;
    assign hit    = wr && (ent_i == IDX_W'(g));
    assign mask_n = (hit && word == 2'd3) ? reg_wdata[0] : mask_q[g];
    assign dat_n  = (hit && word == 2'd2) ? reg_wdata : dat_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alo_q[g]  <= '0;
        ahi_q[g]  <= '0;
        dat_q[g]  <= '0;
        mask_q[g] <= 1'b1;
        used_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        if (hit && word == 2'd0) alo_q[g] <= reg_wdata;
        if (hit && word == 2'd1) ahi_q[g] <= reg_wdata;
        dat_q[g]  <= dat_n;
        mask_q[g] <= mask_n;
        if (!en_next)
          used_q[g] <= 1'b0;
        else if (en_rise || hit)
          used_q[g] <= !mask_n && (dat_n != 32'd0);
        pend_q[g] <= (pend_q[g] | set_pend[g]) & ~(rel_go & rel_oh[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (free) begin
      msg_valid <= send_now || rel_go;
      if (send_now || rel_go) begin
        msg_addr <= {ahi_q[src], alo_q[src]};
        msg_data <= dat_q[src];
      end
    end
  end
endmodule

module msix_vector_table_chk #(
  parameter int NV = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_req,
  input logic          reg_we,
  input logic [1:0]    reg_size,
  input logic [31:0]   reg_rdata,
  input logic          cap_we,
  input logic [15:0]   cap_wdata,
  input logic [15:0]   cap_ctrl,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [63:0]   msg_addr,
  input logic [31:0]   msg_data,
  input logic [NV-1:0] used_q,
  input logic [NV-1:0] pend_q
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r3_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> cap_ctrl[15] == $past(cap_wdata[15]));

  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ctrl[15] && !msg_valid |=> !msg_valid);

  a_r6_disabled_unused: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ctrl[15] |-> used_q == '0);

  a_r4_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we && reg_size != 2'd2 |-> reg_rdata == 32'd0);

  a_r10_clear_sends: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(pend_q) & ~pend_q) |-> msg_valid);
endmodule

bind msix_vector_table msix_vector_table_chk #(.NV(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_size(reg_size), .reg_rdata(reg_rdata), .cap_we(cap_we),
  .cap_wdata(cap_wdata), .cap_ctrl(cap_ctrl), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .used_q(used_q), .pend_q(pend_q)
);

// File: tb/msix_vector_table_tb.sv
module msix_vector_table_tb;
  localparam int NV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'd2;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cap_we = 1'b0;
  logic [15:0] cap_wdata = '0, cap_ctrl;
  logic [31:0] tbl_loc, pba_loc;
  logic        irq_req = 1'b0;
  logic [10:0] irq_vec = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msix_vector_table #(.NUM_VEC(NV), .BIR(2)) u_dut (.*);

  function automatic logic [31:0] lo_of(int v); return 32'hFEE0_0000 | (v << 4); endfunction
  function automatic logic [31:0] hi_of(int v); return 32'h100 + v; endfunction
  function automatic logic [31:0] dat_of(int v); return (v == 3) ? 32'd0 : 32'h40 + v; endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr32(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_req = 0; reg_we = 0; reg_size = 2'd2;
  endtask

  task automatic rd32(logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a; reg_size = sz;
    #1 d = reg_rdata;
    reg_req = 0; reg_size = 2'd2;
  endtask

  task automatic capw(logic [15:0] d);
    @(negedge clk);
    cap_we = 1; cap_wdata = d;
    @(negedge clk);
    cap_we = 0;
  endtask

  task automatic req(int v);
    @(negedge clk);
    irq_req = 1; irq_vec = 11'(v);
    @(negedge clk);
    irq_req = 0;
  endtask

  task automatic chk_msg(string tag, int v);
    chk({tag, " valid"}, 64'(msg_valid), 64'd1);
    chk({tag, " addr"}, msg_addr, {hi_of(v), lo_of(v)});
    chk({tag, " data"}, 64'(msg_data), 64'(dat_of(v)));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 msg_valid", 64'(msg_valid), 0);
    chk("R3 ctrl", 64'(cap_ctrl), 64'h0004);
    chk("R5 tbl_loc", 64'(tbl_loc), 64'h2);
    chk("R5 pba_loc", 64'(pba_loc), 64'h802);
    for (int v = 0; v < NV; v++) begin
      rd32(12'(v*16 + 12), d); chk("R1 mask", 64'(d), 1);
      rd32(12'(v*16 + 8), d);  chk("R1 data", 64'(d), 0);
      rd32(12'(v*16), d);      chk("R1 addr", 64'(d), 0);
    end
    rd32(12'h800, d); chk("R1 pba", 64'(d), 0);
  endtask

  task automatic t_table;
    logic [31:0] d;
    for (int v = 0; v < NV; v++) begin
      wr32(12'(v*16), lo_of(v));
      wr32(12'(v*16 + 4), hi_of(v));
      wr32(12'(v*16 + 8), dat_of(v));
      wr32(12'(v*16 + 12), (v == 4) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
    end
    for (int v = 0; v < NV; v++) begin
      rd32(12'(v*16), d);      chk("R2 lo", 64'(d), 64'(lo_of(v)));
      rd32(12'(v*16 + 4), d);  chk("R2 hi", 64'(d), 64'(hi_of(v)));
      rd32(12'(v*16 + 8), d);  chk("R2 data", 64'(d), 64'(dat_of(v)));
      rd32(12'(v*16 + 12), d); chk("R2 ctrl", 64'(d), (v == 4) ? 1 : 0);
    end
    wr32(12'h800, 32'hFFFF_FFFF);
    rd32(12'h800, d); chk("R5 pba write ignored", 64'(d), 0);
  endtask

  task automatic t_narrow;
    logic [31:0] d;
    wr32(12'h018, 32'hDEAD_BEEF, 2'd0);
    wr32(12'h018, 32'hDEAD_BEEF, 2'd1);
    wr32(12'h01A, 32'hDEAD_BEEF, 2'd2);
    rd32(12'h018, d); chk("R4 narrow write dropped", 64'(d), 64'(dat_of(1)));
    rd32(12'h018, d, 2'd1); chk("R4 half read zero", 64'(d), 0);
    rd32(12'h018, d, 2'd0); chk("R4 byte read zero", 64'(d), 0);
    wr32(12'h058, 32'h1234);
    rd32(12'h058, d); chk("R4 entry beyond table", 64'(d), 0);
  endtask

  task automatic t_enable;
    capw(16'h7FFF); chk("R3 ro bits", 64'(cap_ctrl), 64'h0004);
    capw(16'h8000); chk("R3 enable", 64'(cap_ctrl), 64'h8004);
  endtask

  task automatic t_send;
    logic [31:0] d;
    req(0); chk_msg("R8 vec0", 0);
    req(2); chk_msg("R8 vec2", 2);
    req(3); chk("R7 zero data", 64'(msg_valid), 0);
    req(7); chk("R7 out of range", 64'(msg_valid), 0);
    rd32(12'h800, d); chk("R7 no pending", 64'(d), 0);
    req(4); chk("R9 masked no msg", 64'(msg_valid), 0);
    rd32(12'h800, d); chk("R9 pending bit", 64'(d), 64'h10);
    wr32(12'h04C, 32'h0);
    @(negedge clk); chk_msg("R10 unmask release", 4);
    rd32(12'h800, d); chk("R10 pending cleared", 64'(d), 0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    msg_ready = 0;
    req(0); chk_msg("R11 held msg", 0);
    req(2);
    req(1);
    chk_msg("R11 still held", 0);
    rd32(12'h800, d); chk("R12 pending while busy", 64'(d), 64'h6);
    msg_ready = 1;
    @(negedge clk); chk_msg("R10 lowest first", 1);
    @(negedge clk); chk_msg("R10 next pending", 2);
    @(negedge clk); chk("R10 drained", 64'(msg_valid), 0);
    rd32(12'h800, d); chk("R12 pba empty", 64'(d), 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    capw(16'h0000);
    req(0); chk("R7 disabled", 64'(msg_valid), 0);
    rd32(12'h800, d); chk("R7 disabled no pending", 64'(d), 0);
    wr32(12'h00C, 32'h1);
    wr32(12'h018, 32'h0);
    capw(16'h8000);
    req(1); chk("R6 zero data unusable", 64'(msg_valid), 0);
    req(0); chk("R6 masked unusable", 64'(msg_valid), 0);
    rd32(12'h800, d); chk("R6 pend masked only", 64'(d), 64'h1);
    req(2); chk_msg("R6 usable vector", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_table;
    t_narrow;
    t_enable;
    t_send;
    t_busy;
    t_disable;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule